// File: doc/BRIEF.md
# Counter Input Select and Capture-Edge Clear

This block is the front end of a timer/counter. It decides where the counter's advance strobe comes from. In timer mode the strobe is the internal prescaled tick. In counter mode it comes from edges on one of four external capture pins, and the selected polarity can be rising, falling or both. The same block can also issue a synchronous clear of the counter and its prescaler when a chosen edge appears on a chosen capture channel. The counter, the capture registers and the interrupt logic sit outside this block and only consume its strobes.

Each capture pin is asynchronous. It passes through a two-flop synchronizer. An edge is detected by comparing the synchronized level with the level seen one cycle earlier. Both outputs are registered. A pin transition first sampled at clock edge k therefore shows up as a one-cycle strobe after clock edge k+2. The block has no data stream, so every pin is a plain control or status signal with no handshake.

In counter mode the channel that serves as the count source must not also capture. The block drives a per-channel capture-permit mask. That mask clears the bit of the count channel and leaves the other three channels free to capture.

Top module: `cis_front`

## Requirements
- R1: With `mode` = 0 (timer mode), `count_tick` equals `pre_tick` delayed by one clock, unless a clear is issued in that cycle.
- R2: With `mode` = 1, `count_tick` pulses for one cycle after each rising edge of the capture pin selected by `cnt_sel`. A pin transition first sampled at clock edge k gives a pulse after edge k+2.
- R3: With `mode` = 2, `count_tick` pulses after each falling edge of the selected pin, with the same latency as R2.
- R4: With `mode` = 3, `count_tick` pulses after every edge of either polarity on the selected pin, with the same latency as R2.
- R5: In counter mode, transitions on the three capture pins not selected by `cnt_sel` have no effect on `count_tick`, and `pre_tick` is ignored.
- R6: With `clr_en` = 1, `clear_strobe` pulses for one cycle after the edge chosen by `clr_code`, with the same latency as R2. The channel is `clr_code[2:1]`. Bit `clr_code[0]` = 0 selects the rising edge and 1 selects the falling edge. Codes 0 to 5 therefore cover channels 0 to 2.
- R7: `clr_code` values 6 and 7 never produce `clear_strobe`.
- R8: With `clr_en` = 0, `clear_strobe` stays low whatever `clr_code` and the pins do.
- R9: When a count strobe and a clear fall in the same cycle, `clear_strobe` is 1 and `count_tick` is 0.
- R10: In counter mode, `cap_en` is 0 for the channel selected by `cnt_sel` and 1 for every other channel. In timer mode all four bits of `cap_en` are 1.
- R11: While `rst_n` is low, `count_tick` and `clear_strobe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 4 | Asynchronous capture pins, channels 0 to 3 |
| pre_tick | input | 1 | Prescaled tick used in timer mode |
| mode | input | 2 | 0 timer, 1 rising, 2 falling, 3 both edges |
| cnt_sel | input | 2 | Capture channel used as the count source |
| clr_en | input | 1 | Enables the capture-edge clear |
| clr_code | input | 3 | Channel and edge that trigger a clear |
| count_tick | output | 1 | One-cycle advance strobe for the counter |
| clear_strobe | output | 1 | One-cycle clear for counter and prescaler |
| cap_en | output | 4 | Capture permit per channel |

## Verification
The bench covers every combination of mode, count channel, clear enable and clear code. Under each one it drives a pin sequence that gives every channel both rising and falling transitions, including transitions on several pins in the same cycle. This exposes a design that taps the wrong channel, swaps the polarity of the clear code, or decodes the reserved codes 6 and 7 as channel 3. It also catches a design that lets `pre_tick` or an unselected pin leak into counter mode. Cycles in which the count source and the clear land together check the clear-wins priority; a design with the opposite priority would emit both strobes. The expected latency is modelled exactly, so a missing or extra synchronizer stage shows up as a shifted strobe.

// File: rtl/cis_pkg.sv
package cis_pkg;

  typedef enum logic [1:0] {
    SRC_TIMER = 2'd0,
    SRC_RISE  = 2'd1,
    SRC_FALL  = 2'd2,
    SRC_BOTH  = 2'd3
  } src_mode_e;

  typedef struct packed {
    logic valid;
    logic falling;
  } clr_decode_t;

endpackage

// File: rtl/cis_sync.sv
module cis_sync #(
  parameter int N_CH   = 4,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] pin_async,
  output logic [N_CH-1:0] lvl_now,
  output logic [N_CH-1:0] lvl_prev
);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [STAGES-1:0] chain;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain  <= '0;
        prev_q <= 1'b0;
      end else begin
        chain  <= {chain[STAGES-2:0], pin_async[c]};
        prev_q <= chain[STAGES-1];
      end
    end

    assign lvl_now[c]  = chain[STAGES-1];
    assign lvl_prev[c] = prev_q;
  end

endmodule

// File: rtl/cis_edge.sv
module cis_edge #(
  parameter int N_CH = 4
) (
  input  logic [N_CH-1:0] lvl_now,
  input  logic [N_CH-1:0] lvl_prev,
  output logic [N_CH-1:0] rise,
  output logic [N_CH-1:0] fall
);

  for (genvar c = 0; c < N_CH; c++) begin : g_det
    always_comb begin
      rise[c] = lvl_now[c] & ~lvl_prev[c];
      fall[c] = ~lvl_now[c] & lvl_prev[c];
    end
  end

endmodule

// File: rtl/cis_src_sel.sv
module cis_src_sel
  import cis_pkg::*;
#(
  parameter int N_CH  = 4,
  localparam int SELW = $clog2(N_CH)
) (
  input  logic [1:0]      mode,
  input  logic [SELW-1:0] cnt_sel,
  input  logic            pre_tick,
  input  logic [N_CH-1:0] rise,
  input  logic [N_CH-1:0] fall,
  output logic            src_pulse,
  output logic [N_CH-1:0] cap_en
);

  src_mode_e m;
  logic      r_sel, f_sel;

  always_comb begin
    m     = src_mode_e'(mode);
    r_sel = rise[cnt_sel];
    f_sel = fall[cnt_sel];
    unique case (m)
      SRC_TIMER: src_pulse = pre_tick;
      SRC_RISE:  src_pulse = r_sel;
      SRC_FALL:  src_pulse = f_sel;
      SRC_BOTH:  src_pulse = r_sel | f_sel;
      default:   src_pulse = 1'b0;
    endcase
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_mask
    assign cap_en[c] = (m == SRC_TIMER) || (cnt_sel != SELW'(c));
  end

endmodule

// File: rtl/cis_clr_sel.sv
module cis_clr_sel
  import cis_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int CLR_CH = 3,
  localparam int CODEW = $clog2(2 * CLR_CH)
) (
  input  logic             clr_en,
  input  logic [CODEW-1:0] clr_code,
  input  logic [N_CH-1:0]  rise,
  input  logic [N_CH-1:0]  fall,
  output logic             clr_pulse
);

  clr_decode_t dec;
  logic [N_CH-1:0] hit;

  always_comb begin
    dec.valid   = clr_code < CODEW'(2 * CLR_CH);
    dec.falling = clr_code[0];
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_hit
    if (c < CLR_CH) begin : g_used
      assign hit[c] = (clr_code[CODEW-1:1] == (CODEW-1)'(c)) &&
                      (dec.falling ? fall[c] : rise[c]);
    end else begin : g_unused
      assign hit[c] = 1'b0;
    end
  end

  assign clr_pulse = clr_en && dec.valid && (|hit);

endmodule

// File: rtl/cis_front.sv
module cis_front
  import cis_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int CLR_CH = 3,
  parameter int STAGES = 2,
  localparam int SELW  = $clog2(N_CH),
  localparam int CODEW = $clog2(2 * CLR_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CH-1:0]  cap_pin,
  input  logic             pre_tick,
  input  logic [1:0]       mode,
  input  logic [SELW-1:0]  cnt_sel,
  input  logic             clr_en,
  input  logic [CODEW-1:0] clr_code,
  output logic             count_tick,
  output logic             clear_strobe,
  output logic [N_CH-1:0]  cap_en
);

  logic [N_CH-1:0] lvl_now, lvl_prev, rise, fall;
  logic            src_pulse, clr_pulse;

  cis_sync #(.N_CH(N_CH), .STAGES(STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_async(cap_pin),
    .lvl_now  (lvl_now),
    .lvl_prev (lvl_prev)
  );

  cis_edge #(.N_CH(N_CH)) u_edge (
    .lvl_now (lvl_now),
    .lvl_prev(lvl_prev),
    .rise    (rise),
    .fall    (fall)
  );

  cis_src_sel #(.N_CH(N_CH)) u_src (
    .mode     (mode),
    .cnt_sel  (cnt_sel),
    .pre_tick (pre_tick),
    .rise     (rise),
    .fall     (fall),
    .src_pulse(src_pulse),
    .cap_en   (cap_en)
  );

  cis_clr_sel #(.N_CH(N_CH), .CLR_CH(CLR_CH)) u_clr (
    .clr_en   (clr_en),
    .clr_code (clr_code),
    .rise     (rise),
    .fall     (fall),
    .clr_pulse(clr_pulse)
  );

  // clear has priority over an advance in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_tick   <= 1'b0;
      clear_strobe <= 1'b0;
    end else begin
      count_tick   <= src_pulse & ~clr_pulse;
      clear_strobe <= clr_pulse;
    end
  end

endmodule

// File: rtl/cis_front_chk.sv
module cis_front_chk #(
  parameter int N_CH  = 4,
  parameter int SELW  = 2,
  parameter int CODEW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pre_tick,
  input logic [1:0]       mode,
  input logic [SELW-1:0]  cnt_sel,
  input logic             clr_en,
  input logic [CODEW-1:0] clr_code,
  input logic             count_tick,
  input logic             clear_strobe,
  input logic [N_CH-1:0]  cap_en
);

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_strobe |-> !count_tick);

  assert_reserved_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_code) >= 3'd6) |-> !clear_strobe);

  assert_clear_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_en) |-> !clear_strobe);

  assert_timer_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd0 && !$past(pre_tick)) |-> !count_tick);

  assert_count_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0) |-> ($countones(cap_en) == N_CH - 1 && !cap_en[cnt_sel]));

  assert_timer_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (&cap_en));

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R11: assert (!count_tick && !clear_strobe);
    end
  end

endmodule

bind cis_front cis_front_chk #(.N_CH(N_CH), .SELW(SELW), .CODEW(CODEW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pre_tick    (pre_tick),
  .mode        (mode),
  .cnt_sel     (cnt_sel),
  .clr_en      (clr_en),
  .clr_code    (clr_code),
  .count_tick  (count_tick),
  .clear_strobe(clear_strobe),
  .cap_en      (cap_en)
);

// File: tb/tb_cis_front.sv
module tb_cis_front;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cap_pin = '0;
  logic       pre_tick = 1'b0;
  logic [1:0] mode = '0;
  logic [1:0] cnt_sel = '0;
  logic       clr_en = 1'b0;
  logic [2:0] clr_code = '0;
  logic       count_tick, clear_strobe;
  logic [3:0] cap_en;

  int n_chk = 0;
  int n_bad = 0;
  int warm  = 0;
  logic [3:0] h0 = '0, h1 = '0, h2 = '0, h3 = '0;
  logic       pt0 = 1'b0;

  always #5 clk = ~clk;

  cis_front dut (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .pre_tick(pre_tick),
    .mode(mode), .cnt_sel(cnt_sel), .clr_en(clr_en), .clr_code(clr_code),
    .count_tick(count_tick), .clear_strobe(clear_strobe), .cap_en(cap_en)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s mode=%0d sel=%0d en=%0d code=%0d act=%h exp=%h",
               req, mode, cnt_sel, clr_en, clr_code, act, exp);
    end
  endtask

  // the output seen after edge j depends on pins driven for edges j-2 and j-3
  task automatic step(input logic [3:0] pins, input logic pt);
    logic [3:0] r, f;
    logic       e_clr, e_src;
    string      tag;
    cap_pin = pins;
    pre_tick = pt;
    h3 = h2; h2 = h1; h1 = h0; h0 = pins; pt0 = pt;
    @(negedge clk);
    warm++;
    if (warm < 4) return;
    r = h2 & ~h3;
    f = ~h2 & h3;
    e_clr = clr_en && (clr_code < 3'd6) &&
            (clr_code[0] ? f[clr_code[2:1]] : r[clr_code[2:1]]);
    case (mode)
      2'd0: begin e_src = pt0; tag = "R1"; end
      2'd1: begin e_src = r[cnt_sel]; tag = "R2/R5"; end
      2'd2: begin e_src = f[cnt_sel]; tag = "R3/R5"; end
      default: begin e_src = r[cnt_sel] | f[cnt_sel]; tag = "R4/R5"; end
    endcase
    if (e_src && e_clr) tag = "R9";
    check(tag, {3'b0, count_tick}, {3'b0, e_src & ~e_clr});
    if (!clr_en) tag = "R8";
    else if (clr_code >= 3'd6) tag = "R7";
    else tag = "R6";
    check(tag, {3'b0, clear_strobe}, {3'b0, e_clr});
    check("R10", cap_en, (mode == 2'd0) ? 4'hF : ~(4'b1 << cnt_sel));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11", {2'b0, count_tick, clear_strobe}, 4'h0);
    rst_n = 1'b1;
    for (int cfg = 0; cfg < 256; cfg++) begin
      mode     = cfg[1:0];
      cnt_sel  = cfg[3:2];
      clr_en   = cfg[4];
      clr_code = cfg[7:5];
      for (int i = 0; i < 20; i++) begin
        logic [3:0] p;
        p = 4'((i * 5) ^ (i >> 1) ^ (cfg & 3));
        step(p, i[0] ^ i[2]);
      end
    end
    // single-pin walk: each channel toggles alone with the others idle
    mode = 2'd3; clr_en = 1'b1;
    for (int c = 0; c < 4; c++) begin
      cnt_sel = 2'(c);
      clr_code = 3'(2 * c);
      step(4'b1 << c, 1'b1);
      step(4'b1 << c, 1'b1);
      step(4'b0, 1'b1);
      step(4'b0, 1'b1);
      step(4'b0, 1'b1);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule